// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block tracks the loads in flight in an out-of-order core. Each load takes a slot in a circular queue, in program order, when it is dispatched. The slot holds the load's sequence number. When the load executes, the slot also records its effective address and sets an executed flag. Commit retires loads from the oldest end. A squash removes loads from the youngest end.

When a store executes, the queue looks for loads that are younger than the store, have already executed, and touched the same coarse address region (the address with its low `REGION_SHIFT` bits dropped). These loads read stale data. The oldest such load, counted from the head of the queue, is latched as the single pending violator, and a one-cycle fault pulse tells the core to squash and refetch from that load. The violator stays latched until the core takes it. While it is pending, later stores are not checked.

The block also keeps a load-blocked marker with its own sequence number, which a squash below that number releases. It reports how many memory operations can still be dispatched, which is the smaller of the load-queue and store-queue free space, minus one. All outputs come from registers. The effect of an input is visible on the outputs in the cycle after the clock edge that samples it.

Top module: `lq_order_guard`

## Requirements
- R1: An allocation is accepted when `alloc_valid` is high, `lq_count` is below `DEPTH` and `squash_valid` is low. The load goes into slot `alloc_slot`, which equals (head + `lq_count`) mod `DEPTH`, and `lq_count` goes up by one. `alloc_ready` is low exactly when `lq_count` equals `DEPTH`, and an allocation offered at that time is dropped.
- R2: `exec_valid` for an occupied slot stores `exec_addr` in that slot and marks it executed. `exec_valid` for an unoccupied slot changes nothing, and a newly allocated slot always starts out not executed.
- R3: A store with sequence number S and address A conflicts with a load when all of these hold: the load's slot is occupied, the load has executed, its sequence number is strictly greater than S (unsigned compare), and `addr >> REGION_SHIFT` equals `A >> REGION_SHIFT`. `REGION_SHIFT` defaults to 8. Older loads, loads that have not executed and loads in other regions never conflict.
- R4: When no violator is pending and `st_valid` finds one or more conflicts, the violator becomes the conflicting load closest to the head of the queue. In the next cycle `viol_valid` is high, `viol_slot` and `viol_seq` identify that load, and `st_fault` is high for that one cycle. A store that finds no conflict leaves `viol_valid` low and `st_fault` low.
- R5: While `viol_valid` is high, stores are not checked. `st_fault` stays low, and `viol_slot` and `viol_seq` keep their values.
- R6: `viol_take` while `viol_valid` is high clears `viol_valid` in the next cycle. `viol_take` while `viol_valid` is low has no effect.
- R7: `commit_valid` with number C removes from the head every load whose sequence number is at or below C, and their slots become free again. Commit and allocation in the same cycle both take effect.
- R8: `squash_valid` with number Q removes every load whose sequence number is above Q, from the tail. In that cycle, commit and allocation are ignored.
- R9: `blk_set` raises `blk_active` and records `blk_seq`. Without `blk_set`, a squash whose number is below the recorded number clears `blk_active`. Any other squash leaves it unchanged.
- R10: `free_slots` equals min(`DEPTH` - `lq_count`, `SQ_DEPTH` - `sq_used`) - 1, with the store part taken as 0 when `sq_used` >= `SQ_DEPTH`, and the result saturating at 0.
- R11: After reset the queue is empty, `viol_valid`, `st_fault` and `blk_active` are low, and `alloc_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch a load into the queue |
| alloc_seq | input | SEQ_W | Sequence number of the dispatched load |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_slot | output | IDX_W | Slot the next allocation will use |
| exec_valid | input | 1 | A load has computed its address |
| exec_slot | input | IDX_W | Slot of the executing load |
| exec_addr | input | ADDR_W | Effective address of the executing load |
| st_valid | input | 1 | A store is executing |
| st_seq | input | SEQ_W | Sequence number of the store |
| st_addr | input | ADDR_W | Effective address of the store |
| st_fault | output | 1 | One-cycle ordering fault for the store |
| viol_valid | output | 1 | A violator is pending |
| viol_slot | output | IDX_W | Slot of the pending violator |
| viol_seq | output | SEQ_W | Sequence number of the pending violator |
| viol_take | input | 1 | Consume the pending violator |
| commit_valid | input | 1 | Commit loads up to `commit_seq` |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash loads younger than `squash_seq` |
| squash_seq | input | SEQ_W | Squash boundary |
| blk_set | input | 1 | Mark a load as blocked |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_active | output | 1 | Load-blocked marker |
| sq_used | input | SQ_CW | Occupied store-queue entries |
| free_slots | output | FREE_W | Dispatchable memory operations |
| lq_count | output | CNT_W | Occupied load-queue slots |

## Verification
The bench targets four situations.

1. A store that matches several younger loads after the head has wrapped past the last slot. A picker that counts from slot 0 instead of from the head would report a younger load here.
2. Boundary stores: one whose sequence number equals a load's, one against a load that has not executed, and one into a neighbouring region. A wrong compare or a missing executed flag would raise a false fault in each case.
3. Stores that arrive while a violator is pending. A design that searches anyway would overwrite the violator.
4. Squash edge cases: a squash that arrives together with an allocation, which a wrong design would accept, and squash numbers just above and just below the blocked number, which a wrong design would use to clear the marker at the wrong time.

Saturation of the free count is also checked.

// File: rtl/lq_pkg.sv
package lq_pkg;

    // How the head/count pointers move in a given cycle.
    typedef enum logic [1:0] {
        PTR_HOLD    = 2'd0,
        PTR_SQUASH  = 2'd1,
        PTR_ADVANCE = 2'd2
    } ptr_op_e;

    // Dispatch headroom: smaller of the two free counts, minus one, floored at zero.
    function automatic int unsigned free_min(input int unsigned lq_free,
                                             input int unsigned sq_depth,
                                             input int unsigned sq_used);
        int unsigned sq_free;
        int unsigned m;
        sq_free = (sq_used >= sq_depth) ? 0 : sq_depth - sq_used;
        m       = (lq_free < sq_free) ? lq_free : sq_free;
        return (m == 0) ? 0 : m - 1;
    endfunction

    // Coarse region compare: addresses agree once the low bits are dropped.
    function automatic logic same_region(input logic [63:0] a,
                                         input logic [63:0] b,
                                         input int unsigned sh);
        return (a >> sh) == (b >> sh);
    endfunction

endpackage

// File: rtl/lq_storage.sv
module lq_storage #(
    parameter  int DEPTH  = 8,
    parameter  int SEQ_W  = 16,
    parameter  int ADDR_W = 32,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc_we,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic [SEQ_W-1:0]             alloc_seq,
    input  logic                         exec_we,
    input  logic [IDX_W-1:0]             exec_idx,
    input  logic [ADDR_W-1:0]            exec_addr,
    output logic [DEPTH-1:0][SEQ_W-1:0]  seq_o,
    output logic [DEPTH-1:0][ADDR_W-1:0] addr_o,
    output logic [DEPTH-1:0]             done_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                seq_o[g]  <= '0;
                addr_o[g] <= '0;
                done_o[g] <= 1'b0;
            end else if (alloc_we && alloc_idx == IDX_W'(g)) begin
                seq_o[g]  <= alloc_seq;
                addr_o[g] <= '0;
                done_o[g] <= 1'b0;
            end else if (exec_we && exec_idx == IDX_W'(g)) begin
                addr_o[g] <= exec_addr;
                done_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lq_conflict_scan.sv
module lq_conflict_scan #(
    parameter  int DEPTH        = 8,
    parameter  int SEQ_W        = 16,
    parameter  int ADDR_W       = 32,
    parameter  int REGION_SHIFT = 8,
    localparam int IDX_W        = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0]             occ,
    input  logic [DEPTH-1:0][SEQ_W-1:0]  seq,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0]             done,
    input  logic [IDX_W-1:0]             head,
    input  logic                         probe,
    input  logic [SEQ_W-1:0]             st_seq,
    input  logic [ADDR_W-1:0]            st_addr,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [DEPTH-1:0] match;
    logic [DEPTH-1:0] rot;
    logic [IDX_W-1:0] first;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = probe && occ[g] && done[g] && (seq[g] > st_seq) &&
                          lq_pkg::same_region(64'(addr[g]), 64'(st_addr), REGION_SHIFT);
    end

    // Rotate so position 0 is the head, then take the lowest set position.
    always_comb begin
        logic [IDX_W-1:0] p;
        rot   = '0;
        first = '0;
        for (int k = 0; k < DEPTH; k++) begin
            p      = head + IDX_W'(k);
            rot[k] = match[p];
        end
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (rot[k]) first = IDX_W'(k);
        end
    end

    assign hit     = |match;
    assign hit_idx = head + first;

    AST_PICK_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
        hit |-> match[hit_idx]) else $error("picked slot does not conflict"); // R4

endmodule

// File: rtl/lq_retire_count.sv
module lq_retire_count #(
    parameter  int DEPTH = 8,
    parameter  int SEQ_W = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [DEPTH-1:0]            occ,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
    input  logic [SEQ_W-1:0]            commit_seq,
    input  logic [SEQ_W-1:0]            squash_seq,
    output logic [CNT_W-1:0]            n_commit,
    output logic [CNT_W-1:0]            n_squash
);

    // Program order from the head means the counts equal prefix/suffix lengths.
    always_comb begin
        n_commit = '0;
        n_squash = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (occ[k] && seq[k] <= commit_seq) n_commit = n_commit + CNT_W'(1);
            if (occ[k] && seq[k] >  squash_seq) n_squash = n_squash + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lq_order_guard.sv
module lq_order_guard #(
    parameter  int DEPTH        = 8,
    parameter  int SQ_DEPTH     = 8,
    parameter  int SEQ_W        = 16,
    parameter  int ADDR_W       = 32,
    parameter  int REGION_SHIFT = 8,
    localparam int IDX_W        = $clog2(DEPTH),
    localparam int CNT_W        = IDX_W + 1,
    localparam int SQ_CW        = $clog2(SQ_DEPTH + 1),
    localparam int FREE_W       = $clog2(((DEPTH > SQ_DEPTH) ? DEPTH : SQ_DEPTH) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_slot,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_slot,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              st_fault,
    output logic              viol_valid,
    output logic [IDX_W-1:0]  viol_slot,
    output logic [SEQ_W-1:0]  viol_seq,
    input  logic              viol_take,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              blk_set,
    input  logic [SEQ_W-1:0]  blk_seq,
    output logic              blk_active,
    input  logic [SQ_CW-1:0]  sq_used,
    output logic [FREE_W-1:0] free_slots,
    output logic [CNT_W-1:0]  lq_count
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] slot;
        logic [SEQ_W-1:0] seq;
    } viol_t;

    logic [IDX_W-1:0]             head_q;
    logic [CNT_W-1:0]             count_q;
    logic [DEPTH-1:0]             occ;
    logic [DEPTH-1:0][SEQ_W-1:0]  seq_arr;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_arr;
    logic [DEPTH-1:0]             done_arr;
    logic [CNT_W-1:0]             n_commit, n_squash, n_take;
    logic                         alloc_go, exec_go, probe, hit;
    logic [IDX_W-1:0]             hit_idx;
    viol_t                        viol_q;
    logic                         st_fault_q;
    logic                         blk_q;
    logic [SEQ_W-1:0]             blk_seq_q;
    lq_pkg::ptr_op_e              ptr_op;

    // Occupancy from distance to head.
    for (genvar g = 0; g < DEPTH; g++) begin : g_occ
        logic [IDX_W-1:0] rel;
        assign rel    = IDX_W'(g) - head_q;
        assign occ[g] = {1'b0, rel} < count_q;
    end

    assign alloc_ready = (count_q != CNT_W'(DEPTH));
    assign alloc_slot  = head_q + count_q[IDX_W-1:0];
    assign alloc_go    = alloc_valid && alloc_ready && !squash_valid;
    assign exec_go     = exec_valid && occ[exec_slot];
    assign probe       = st_valid && !viol_q.vld;
    assign n_take      = commit_valid ? n_commit : '0;

    always_comb begin
        if (squash_valid)                  ptr_op = lq_pkg::PTR_SQUASH;
        else if (commit_valid || alloc_go) ptr_op = lq_pkg::PTR_ADVANCE;
        else                               ptr_op = lq_pkg::PTR_HOLD;
    end

    lq_storage #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .alloc_we  (alloc_go),
        .alloc_idx (alloc_slot),
        .alloc_seq (alloc_seq),
        .exec_we   (exec_go),
        .exec_idx  (exec_slot),
        .exec_addr (exec_addr),
        .seq_o     (seq_arr),
        .addr_o    (addr_arr),
        .done_o    (done_arr)
    );

    lq_conflict_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                       .REGION_SHIFT(REGION_SHIFT)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .occ     (occ),
        .seq     (seq_arr),
        .addr    (addr_arr),
        .done    (done_arr),
        .head    (head_q),
        .probe   (probe),
        .st_seq  (st_seq),
        .st_addr (st_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    lq_retire_count #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_retire (
        .occ        (occ),
        .seq        (seq_arr),
        .commit_seq (commit_seq),
        .squash_seq (squash_seq),
        .n_commit   (n_commit),
        .n_squash   (n_squash)
    );

    // Pointer update.
    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            case (ptr_op)
                lq_pkg::PTR_SQUASH:  count_q <= count_q - n_squash;
                lq_pkg::PTR_ADVANCE: begin
                    head_q  <= head_q + IDX_W'(n_take);
                    count_q <= count_q - n_take + CNT_W'(alloc_go);
                end
                default: ;
            endcase
        end
    end

    // Single pending violator and fault pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q     <= '0;
            st_fault_q <= 1'b0;
        end else begin
            st_fault_q <= 1'b0;
            if (viol_q.vld) begin
                if (viol_take) viol_q.vld <= 1'b0;
            end else if (st_valid) begin
                viol_q.vld  <= hit;
                viol_q.slot <= hit_idx;
                viol_q.seq  <= seq_arr[hit_idx];
                st_fault_q  <= hit;
            end
        end
    end

    // Load-blocked marker.
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q     <= 1'b0;
            blk_seq_q <= '0;
        end else if (blk_set) begin
            blk_q     <= 1'b1;
            blk_seq_q <= blk_seq;
        end else if (squash_valid && squash_seq < blk_seq_q) begin
            blk_q     <= 1'b0;
        end
    end

    always_comb begin
        free_slots = FREE_W'(lq_pkg::free_min(32'(DEPTH) - 32'(count_q),
                                              32'(SQ_DEPTH), 32'(sq_used)));
    end

    assign st_fault   = st_fault_q;
    assign viol_valid = viol_q.vld;
    assign viol_slot  = viol_q.slot;
    assign viol_seq   = viol_q.seq;
    assign blk_active = blk_q;
    assign lq_count   = count_q;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH)) else $error("count above depth"); // R1
    AST_FAULT_HAS_VIOL: assert property (@(posedge clk) disable iff (rst)
        st_fault_q |-> viol_q.vld) else $error("fault without violator"); // R4
    AST_VIOL_HELD: assert property (@(posedge clk) disable iff (rst)
        (viol_q.vld && !viol_take) |=> (viol_q.vld && $stable(viol_q.slot) && $stable(viol_q.seq)))
        else $error("pending violator changed"); // R5
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (viol_q.vld && viol_take) |=> !viol_q.vld) else $error("take did not clear"); // R6
    AST_SQUASH_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> count_q <= $past(count_q)) else $error("queue grew on squash"); // R8
    AST_BLK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (squash_valid && !blk_set && squash_seq < blk_seq_q) |=> !blk_q)
        else $error("blocked marker kept"); // R9

endmodule

// File: tb/lq_order_guard_tb.sv
`timescale 1ns/1ps
module lq_order_guard_tb_top;

    localparam int D  = 8;
    localparam int SQ = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 0;  logic [15:0] alloc_seq = 0;
    logic        alloc_ready;      logic [2:0]  alloc_slot;
    logic        exec_valid = 0;   logic [2:0]  exec_slot = 0;  logic [31:0] exec_addr = 0;
    logic        st_valid = 0;     logic [15:0] st_seq = 0;     logic [31:0] st_addr = 0;
    logic        st_fault, viol_valid;
    logic [2:0]  viol_slot;        logic [15:0] viol_seq;
    logic        viol_take = 0;
    logic        commit_valid = 0; logic [15:0] commit_seq = 0;
    logic        squash_valid = 0; logic [15:0] squash_seq = 0;
    logic        blk_set = 0;      logic [15:0] blk_seq = 0;
    logic        blk_active;
    logic [3:0]  sq_used = 0;
    logic [3:0]  free_slots;
    logic [3:0]  lq_count;

    lq_order_guard dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .exec_valid(exec_valid), .exec_slot(exec_slot), .exec_addr(exec_addr),
        .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr), .st_fault(st_fault),
        .viol_valid(viol_valid), .viol_slot(viol_slot), .viol_seq(viol_seq), .viol_take(viol_take),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .blk_set(blk_set), .blk_seq(blk_seq), .blk_active(blk_active),
        .sq_used(sq_used), .free_slots(free_slots), .lq_count(lq_count)
    );

    always #4 clk = ~clk; // 125 MHz

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // Reference state
    int m_seq [D];
    int m_addr[D];
    bit m_exec[D];
    int m_head = 0, m_cnt = 0;
    bit m_viol = 0; int m_vslot = 0, m_vseq = 0;
    bit m_fault = 0;
    bit m_blk = 0;  int m_bseq = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_free();
        int lf, sf, m;
        lf = D - m_cnt;
        sf = (int'(sq_used) >= SQ) ? 0 : SQ - int'(sq_used);
        m  = (lf < sf) ? lf : sf;
        return (m == 0) ? 0 : m - 1;
    endfunction

    function automatic bit is_occ(int s);
        return ((s - m_head + D) % D) < m_cnt;
    endfunction

    task automatic check_all(string ctx);
        chk({ctx, " R1 lq_count"}, int'(lq_count), m_cnt);
        chk({ctx, " R1 alloc_ready"}, int'(alloc_ready), int'(m_cnt < D));
        if (m_cnt < D) chk({ctx, " R1 alloc_slot"}, int'(alloc_slot), (m_head + m_cnt) % D);
        chk({ctx, " R10 free_slots"}, int'(free_slots), exp_free());
        chk({ctx, " R5 viol_valid"}, int'(viol_valid), int'(m_viol));
        if (m_viol) begin
            chk({ctx, " R4 viol_slot"}, int'(viol_slot), m_vslot);
            chk({ctx, " R4 viol_seq"}, int'(viol_seq), m_vseq);
        end
        chk({ctx, " R3 st_fault"}, int'(st_fault), int'(m_fault));
        chk({ctx, " R9 blk_active"}, int'(blk_active), int'(m_blk));
    endtask

    task automatic idle_drv();
        alloc_valid = 0; exec_valid = 0; st_valid = 0; viol_take = 0;
        commit_valid = 0; squash_valid = 0; blk_set = 0;
    endtask

    // Apply driven inputs for one cycle, advance reference, check outputs.
    task automatic step(string ctx);
        bit found; int fs, nc, ns, slot; bit aok;
        found = 0; fs = 0;
        m_fault = 0;
        if (m_viol) begin
            if (viol_take) m_viol = 0;
        end else if (st_valid) begin
            for (int k = 0; k < m_cnt; k++) begin
                slot = (m_head + k) % D;
                if (!found && m_exec[slot] && m_seq[slot] > int'(st_seq) &&
                    (m_addr[slot] >>> 8) == (int'(st_addr) >>> 8)) begin
                    found = 1; fs = slot;
                end
            end
            if (found) begin m_viol = 1; m_vslot = fs; m_vseq = m_seq[fs]; m_fault = 1; end
        end
        if (exec_valid && is_occ(int'(exec_slot))) begin
            m_addr[exec_slot] = int'(exec_addr);
            m_exec[exec_slot] = 1;
        end
        aok = alloc_valid && (m_cnt < D) && !squash_valid;
        if (squash_valid) begin
            ns = 0;
            for (int s = 0; s < D; s++) if (is_occ(s) && m_seq[s] > int'(squash_seq)) ns++;
            m_cnt = m_cnt - ns;
        end else begin
            nc = 0;
            if (commit_valid)
                for (int s = 0; s < D; s++) if (is_occ(s) && m_seq[s] <= int'(commit_seq)) nc++;
            if (aok) begin
                slot = (m_head + m_cnt) % D;
                m_seq[slot] = int'(alloc_seq); m_addr[slot] = 0; m_exec[slot] = 0;
            end
            m_head = (m_head + nc) % D;
            m_cnt  = m_cnt - nc + int'(aok);
        end
        if (blk_set) begin m_blk = 1; m_bseq = int'(blk_seq); end
        else if (squash_valid && int'(squash_seq) < m_bseq) m_blk = 0;
        @(posedge clk);
        @(negedge clk);
        idle_drv();
        check_all(ctx);
    endtask

    task automatic do_alloc(int s);
        alloc_valid = 1; alloc_seq = 16'(s); step("R1 alloc");
    endtask
    task automatic do_exec(int sl, int a);
        exec_valid = 1; exec_slot = 3'(sl); exec_addr = 32'(a); step("R2 exec");
    endtask
    task automatic do_store(int s, int a, string ctx);
        st_valid = 1; st_seq = 16'(s); st_addr = 32'(a); step(ctx);
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin m_seq[i] = 0; m_addr[i] = 0; m_exec[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R11 reset");
        chk("R11 alloc_slot zero", int'(alloc_slot), 0);

        // Fill, then offer one more (R1 full drop)
        for (int i = 0; i < D; i++) do_alloc(10 + i);
        alloc_valid = 1; alloc_seq = 16'd40; step("R1 full drop");
        // Unexecuted younger load in region 4 (R3)
        do_store(11, 32'h480, "R3 unexecuted");
        do_exec(0, 32'h100); do_exec(2, 32'h150); do_exec(3, 32'h1FF); do_exec(1, 32'h2AB);
        // Equal seq not younger; slot3 is the hit (R3)
        do_store(12, 32'h1C0, "R3 strict younger");
        viol_take = 1; step("R6 take");
        // Three conflicts, oldest wins (R4)
        do_store(9, 32'h111, "R4 oldest");
        do_store(9, 32'h2AB, "R5 pending ignore");
        viol_take = 1; step("R6 take2");
        viol_take = 1; step("R6 take idle");
        do_store(9, 32'h3AB, "R3 other region");
        // Commit through seq 12 (R7)
        commit_valid = 1; commit_seq = 16'd12; step("R7 commit");
        do_alloc(20); do_alloc(21); do_alloc(22);
        do_exec(5, 32'h710); do_exec(1, 32'h720);
        // Wrapped head: slot5 older than slot1 (R4)
        do_store(14, 32'h7FF, "R4 wrap oldest");
        viol_take = 1; step("R6 take3");
        // Blocked marker and squash (R8, R9)
        blk_set = 1; blk_seq = 16'd18; step("R9 set");
        squash_valid = 1; squash_seq = 16'd20; alloc_valid = 1; alloc_seq = 16'd50;
        step("R8 squash with alloc");
        squash_valid = 1; squash_seq = 16'd15; step("R9 squash below");
        // Free count (R10)
        sq_used = 4'd6; step("R10 sq limited");
        sq_used = 4'd8; step("R10 saturate");
        sq_used = 4'd0;
        // Exec to an unoccupied slot is dropped (R2)
        do_exec(7, 32'h900);
        do_alloc(30); do_alloc(31); do_alloc(32);
        do_store(29, 32'h900, "R2 stale exec");

        // Constrained random phase
        begin
            int nxt, oldest; int r;
            r = $urandom(32'd1234);
            nxt = 60;
            for (int it = 0; it < 3000; it++) begin
                oldest = nxt - 14;
                alloc_valid = ($urandom % 3) != 0;
                alloc_seq   = 16'(nxt);
                exec_valid  = $urandom % 2;
                exec_slot   = 3'($urandom % D);
                exec_addr   = 32'((($urandom % 4) << 8) | ($urandom % 256));
                st_valid    = ($urandom % 3) == 0;
                st_seq      = 16'(nxt - 1 - int'($urandom % 12));
                st_addr     = 32'((($urandom % 4) << 8) | ($urandom % 256));
                viol_take   = ($urandom % 4) == 0;
                commit_valid = ($urandom % 5) == 0;
                commit_seq  = 16'(oldest + int'($urandom % 8));
                squash_valid = ($urandom % 12) == 0;
                squash_seq  = 16'(nxt - 1 - int'($urandom % 8));
                blk_set     = ($urandom % 20) == 0;
                blk_seq     = 16'(nxt - int'($urandom % 6));
                sq_used     = 4'($urandom % 10 > 8 ? 8 : $urandom % 9);
                step("R3 R4 R7 R8 random");
                nxt = nxt + 1 + int'($urandom % 2);
            end
        end

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule